// File: doc/BRIEF.md
# Multi-Queue Write Port Selector

This block is the shared write side of a sixteen-queue buffer. A producer puts a 7-bit address on the write address bus and raises the address enable for one clock. The upper three address bits name one of up to eight cascaded devices. The lower four bits name a queue inside that device. Once a device is selected, words from the producer go to that queue, one per clock, for as long as write enable is held low. The block turns this into a write strobe, a queue index and a data word for the storage behind it. It also returns a registered full flag for the queue most recently selected.

A queue change costs no bus cycles. On the edge that selects a new queue, and on the edge after it, words still go to the previous queue. From the second edge on, words go to the new queue. The full flag already reflects the new queue one edge before writes start landing there. A queue whose full bit is set never receives a write. A selection that names another device leaves this device idle until it is selected again. Until configuration is complete, the block ignores selections and issues no writes.

Top module: `mqw_write_port`

## Requirements
- R1: The write address splits into a queue field, bits [3:0], and a device field, bits [6:4]. The device field is compared with the static `dev_id` input.
- R2: A selection is taken on a rising edge where `addr_en` is high and `cfg_done` is high. The level of `wr_en_n` on that edge has no effect on the selection.
- R3: A selection stays in force until the next selection.
- R4: On every edge, `full_flag` loads the full bit of the queue of the selection that was in force before that edge. This means it shows the new queue from the edge after the select edge onward. It is 1 after reset and whenever the selection in force does not address this device.
- R5: On the select edge and on the edge after it, a word is written to the previously selected queue when `wr_en_n` is low. Nothing is written on those edges when `wr_en_n` is high.
- R6: From the second edge after the select edge onward, writes go to the newly selected queue.
- R7: `stg_wr` is never high while the full bit of the target queue is set. A write to a full queue is dropped.
- R8: After a selection whose device field differs from `dev_id` becomes active, `stg_wr` stays low until a matching selection becomes active.
- R9: While `cfg_done` is low, or before any selection is active, `stg_wr` is low and address-enable cycles are ignored.
- R10: Consecutive selections must be separated by at least two clock cycles. The block handles selections at exactly that spacing correctly.
- R11: When `stg_wr` is high, `stg_q` is the active queue index and `stg_data` equals `wr_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_done | input | 1 | Configuration complete; enables selections and writes |
| dev_id | input | 3 | Static identity of this device in a cascade |
| wr_addr | input | 7 | Device field [6:4] and queue field [3:0] |
| addr_en | input | 1 | Take a selection on this edge |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Write word |
| q_full_vec | input | 16 | Full status, one bit per queue |
| stg_wr | output | 1 | Write strobe toward storage |
| stg_q | output | 4 | Target queue index |
| stg_data | output | 18 | Word toward storage |
| full_flag | output | 1 | Registered full flag of the selected queue |

## Verification
On every cycle, the embedded properties check the following: a selection is captured and then held, the previous queue keeps receiving writes through the handover cycle, the new queue takes over on the following edge, and the full flag follows the selected queue's status. They also check that no strobe is issued into a full queue, while deselected, before configuration, or with write enable high, and that the selection spacing is respected. Whether whole write streams land in the right queue across a switch, with the right words, only shows when the bench's behavioural model is compared against the ports. The same holds for a selection that names an already full queue, for selections made before configuration, and for a foreign device selection followed by reselection.

// File: rtl/mqw_pkg.sv
package mqw_pkg;
  localparam int Q_BITS   = 4;
  localparam int DEV_BITS = 3;
  localparam int ADDR_W   = Q_BITS + DEV_BITS;
  localparam int N_QUEUES = 1 << Q_BITS;

  typedef logic [Q_BITS-1:0]   qidx_t;
  typedef logic [DEV_BITS-1:0] devid_t;
  typedef logic [ADDR_W-1:0]   waddr_t;

  // a selection: queue index plus "addresses this device"
  typedef struct packed {
    logic  ok;
    qidx_t q;
  } sel_t;

  function automatic qidx_t addr_queue(waddr_t a);
    return a[Q_BITS-1:0];
  endfunction

  function automatic devid_t addr_dev(waddr_t a);
    return a[ADDR_W-1:Q_BITS];
  endfunction

  function automatic logic id_hit(waddr_t a, devid_t id);
    return addr_dev(a) == id;
  endfunction
endpackage

// File: rtl/mqw_addr_decode.sv
module mqw_addr_decode
  import mqw_pkg::*;
(
  input  logic   cfg_done,
  input  logic   addr_en,
  input  waddr_t wr_addr,
  input  devid_t dev_id,
  output logic   sel_ev,
  output sel_t   sel_new
);
  // a selection event needs configuration complete (R9)
  assign sel_ev     = addr_en & cfg_done;
  assign sel_new.q  = addr_queue(wr_addr);
  assign sel_new.ok = id_hit(wr_addr, dev_id);
endmodule

// File: rtl/mqw_sel_track.sv
module mqw_sel_track
  import mqw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_ev,
  input  sel_t sel_new,
  output sel_t sel_cur,
  output sel_t act,
  output logic hand
);
  // sel_cur: latest selection; act: queue that writes go to;
  // hand: one cycle between select edge and takeover edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_cur <= '0;
      act     <= '0;
      hand    <= 1'b0;
    end else begin
      if (hand) act <= sel_cur;
      if (sel_ev) begin
        sel_cur <= sel_new;
        hand    <= 1'b1;
      end else begin
        hand    <= 1'b0;
      end
    end
  end

  AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ev |=> sel_cur == $past(sel_new)); // R2
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ev |=> sel_cur == $past(sel_cur)); // R3
  AST_HANDOVER_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ev && !hand) |=> act == $past(act)); // R5
  AST_TAKEOVER_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    hand |=> act == $past(sel_cur)); // R6
  AST_SEL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    hand |-> !sel_ev); // R10
endmodule

// File: rtl/mqw_wr_gate.sv
module mqw_wr_gate
  import mqw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_done,
  input  logic                wr_en_n,
  input  sel_t                act,
  input  sel_t                sel_cur,
  input  logic [N_QUEUES-1:0] q_full_vec,
  output logic                stg_wr,
  output logic                full_flag
);
  logic act_full;
  logic flag_next;

  assign act_full  = q_full_vec[act.q];
  assign stg_wr    = cfg_done & act.ok & ~wr_en_n & ~act_full;
  // no selection addressing this device reads as full
  assign flag_next = sel_cur.ok ? q_full_vec[sel_cur.q] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_flag <= 1'b1;
    else        full_flag <= flag_next;
  end

  AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cur.ok |=> full_flag == $past(q_full_vec[sel_cur.q])); // R4
  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_cur.ok |=> full_flag); // R4
endmodule

// File: rtl/mqw_write_port.sv
module mqw_write_port
  import mqw_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_done,
  input  logic [DEV_BITS-1:0] dev_id,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                addr_en,
  input  logic                wr_en_n,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [N_QUEUES-1:0] q_full_vec,
  output logic                stg_wr,
  output logic [Q_BITS-1:0]   stg_q,
  output logic [DATA_W-1:0]   stg_data,
  output logic                full_flag
);
  logic sel_ev;
  sel_t sel_new;
  sel_t sel_cur;
  sel_t act;
  logic hand;

  mqw_addr_decode u_dec (
    .cfg_done (cfg_done),
    .addr_en  (addr_en),
    .wr_addr  (wr_addr),
    .dev_id   (dev_id),
    .sel_ev   (sel_ev),
    .sel_new  (sel_new)
  );

  mqw_sel_track u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_ev  (sel_ev),
    .sel_new (sel_new),
    .sel_cur (sel_cur),
    .act     (act),
    .hand    (hand)
  );

  mqw_wr_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_done   (cfg_done),
    .wr_en_n    (wr_en_n),
    .act        (act),
    .sel_cur    (sel_cur),
    .q_full_vec (q_full_vec),
    .stg_wr     (stg_wr),
    .full_flag  (full_flag)
  );

  assign stg_q    = act.q;
  assign stg_data = wr_data;

  AST_NO_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stg_wr |-> !q_full_vec[stg_q]); // R7
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act.ok |-> !stg_wr); // R8
  AST_CFG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !stg_wr); // R9
  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_done && addr_en) |=> $stable(sel_cur)); // R9
  AST_WREN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_n |-> !stg_wr); // R5
endmodule

// File: tb/mqw_write_port_bench.sv
module mqw_write_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_done = 1'b0;
  logic [2:0]  dev_id = 3'd5;
  logic [6:0]  wr_addr = '0;
  logic        addr_en = 1'b0;
  logic        wr_en_n = 1'b1;
  logic [17:0] wr_data = 18'h00001;
  logic [15:0] q_full = '0;
  logic        stg_wr;
  logic [3:0]  stg_q;
  logic [17:0] stg_data;
  logic        full_flag;

  int    errs = 0;
  int    checks = 0;
  int    edge_n = 0;
  int    s_edge[$];
  int    s_q[$];
  bit    s_ok[$];
  bit    exp_full = 1'b1;
  string cur_req = "R9";

  always #5 clk = ~clk;

  mqw_write_port u_mqw_write_port (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .dev_id(dev_id),
    .wr_addr(wr_addr), .addr_en(addr_en), .wr_en_n(wr_en_n),
    .wr_data(wr_data), .q_full_vec(q_full), .stg_wr(stg_wr),
    .stg_q(stg_q), .stg_data(stg_data), .full_flag(full_flag)
  );

  task automatic chk(bit ok, string req, string what, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  // latest recorded selection made on an edge numbered <= lim
  function automatic bit find_sel(int lim, output int q, output bit ok);
    q = 0; ok = 1'b0;
    for (int i = s_edge.size() - 1; i >= 0; i--) begin
      if (s_edge[i] <= lim) begin
        q = s_q[i]; ok = s_ok[i];
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  // reference model: advance on every edge
  always @(posedge clk) begin
    int  fq;
    bit  fok;
    if (!rst_n) begin
      edge_n = 0;
      s_edge.delete(); s_q.delete(); s_ok.delete();
      exp_full = 1'b1;
    end else begin
      edge_n++;
      if (find_sel(edge_n - 1, fq, fok) && fok) exp_full = q_full[fq];
      else exp_full = 1'b1;
      if (cfg_done && addr_en) begin
        s_edge.push_back(edge_n);
        s_q.push_back(int'(wr_addr[3:0]));
        s_ok.push_back(wr_addr[6:4] == dev_id);
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    int tq;
    bit tok;
    bit found;
    bit exp_wr;
    if (rst_n) begin
      found  = find_sel(edge_n - 1, tq, tok);
      exp_wr = cfg_done && found && tok && !wr_en_n && !q_full[tq];
      chk(stg_wr == exp_wr, cur_req, "stg_wr", int'(stg_wr), int'(exp_wr));
      if (exp_wr) begin
        chk(stg_q == tq[3:0], cur_req, "stg_q", int'(stg_q), tq);
        chk(stg_data == wr_data, "R11", "stg_data", int'(stg_data), int'(wr_data));
      end
      chk(full_flag == exp_full, cur_req, "full_flag", int'(full_flag), int'(exp_full));
    end
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
      wr_data = wr_data + 18'h01357;
    end
  endtask

  task automatic sel(logic [2:0] dev, logic [3:0] q);
    wr_addr = {dev, q};
    addr_en = 1'b1;
    cyc(1);
    addr_en = 1'b0;
    wr_addr = 7'h7f;
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk(stg_wr == 1'b0, "R9", "reset stg_wr", int'(stg_wr), 0);
    chk(full_flag == 1'b1, "R4", "reset full_flag", int'(full_flag), 1);
    rst_n = 1'b1;
    // R9: selections before configuration are ignored
    cur_req = "R9";
    wr_en_n = 1'b0;
    sel(3'd5, 4'd2);
    cyc(4);
    chk(stg_wr == 1'b0, "R9", "write before cfg", int'(stg_wr), 0);
    cfg_done = 1'b1;
    cyc(3);
    chk(stg_wr == 1'b0, "R9", "no selection yet", int'(stg_wr), 0);
    // R2, R3: wr_en high during the select edge does not matter
    cur_req = "R2";
    wr_en_n = 1'b1;
    sel(3'd5, 4'd3);
    wr_en_n = 1'b0;
    cyc(6);
    cur_req = "R3";
    chk(stg_wr && stg_q == 4'd3, "R3", "held queue 3", int'(stg_q), 3);
    // R5, R6: switch while streaming
    cur_req = "R5";
    sel(3'd5, 4'd9);
    chk(stg_q == 4'd3, "R5", "handover keeps old queue", int'(stg_q), 3);
    cyc(1);
    cur_req = "R6";
    chk(stg_q == 4'd9, "R6", "new queue takes over", int'(stg_q), 9);
    cyc(3);
    // R5: no writes when enable high across the switch
    cur_req = "R5";
    wr_en_n = 1'b1;
    sel(3'd5, 4'd12);
    chk(stg_wr == 1'b0, "R5", "enable high in handover", int'(stg_wr), 0);
    cyc(1);
    wr_en_n = 1'b0;
    cyc(3);
    // R7: queue fills, writes stop
    cur_req = "R7";
    q_full[12] = 1'b1;
    #1;
    chk(stg_wr == 1'b0, "R7", "full queue blocked", int'(stg_wr), 0);
    cyc(2);
    chk(full_flag == 1'b1, "R4", "flag shows full", int'(full_flag), 1);
    // R4: flag tracks newly selected empty queue
    cur_req = "R4";
    sel(3'd5, 4'd0);
    cyc(2);
    chk(full_flag == 1'b0, "R4", "flag of queue 0", int'(full_flag), 0);
    // R7: select an already full queue, then it drains
    cur_req = "R7";
    q_full[15] = 1'b1;
    sel(3'd5, 4'd15);
    cyc(3);
    chk(stg_wr == 1'b0, "R7", "full at selection", int'(stg_wr), 0);
    q_full[15] = 1'b0;
    #1;
    chk(stg_wr == 1'b1, "R7", "queue drained", int'(stg_wr), 1);
    cyc(2);
    // R1, R8: foreign device deselects
    cur_req = "R8";
    sel(3'd2, 4'd4);
    cyc(3);
    chk(stg_wr == 1'b0, "R8", "deselected writes", int'(stg_wr), 0);
    chk(full_flag == 1'b1, "R1", "foreign id flag", int'(full_flag), 1);
    sel(3'd5, 4'd4);
    cyc(2);
    chk(stg_wr && stg_q == 4'd4, "R8", "reselected", int'(stg_q), 4);
    // R10: selections at minimum spacing
    cur_req = "R10";
    sel(3'd5, 4'd7);
    cyc(1);
    sel(3'd5, 4'd8);
    cyc(1);
    chk(stg_q == 4'd8, "R10", "back-to-back switch", int'(stg_q), 8);
    // R11: data stream with full bit toggling
    cur_req = "R11";
    for (int k = 0; k < 8; k++) begin
      q_full[8] = k[0];
      cyc(1);
    end
    wr_en_n = 1'b1;
    cyc(2);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule